// File: doc/BRIEF.md
# Programmable Periodic/One-Shot Down Timer

This block is one down-counting timer channel. A tick enable input, pulsing once per microsecond in a typical system, advances the counter. Software programs it through a two-word register bus. The trigger word carries the run flag, the repeat flag and a 29-bit reload value. The status word reads back the live count and takes a write that acknowledges the interrupt. When the count runs out, a level-high interrupt is latched. In repeat mode the counter reloads and carries on. In single-shot mode the timer stops.

To wait N ticks, software programs N-1, so a value of 0 expires on the first tick. To get a periodic interrupt at rate HZ from a 1 MHz tick, the reload value is 1000000/HZ - 1. The usual way to reprogram is to write 0 to the trigger word first and then write the new setting. A write while the timer runs also restarts it at once from the new value.

Top module: `dtmr_channel`

## Requirements
- R1: After the synchronous active-high reset, `irq` is 0, the count is 0, the timer is stopped, and both register words read 0.
- R2: A write to word 0 (the trigger word) takes bit 31 as run, bit 30 as repeat and bits 28:0 as the reload value. The count equals that value in the cycle after the write. If a tick arrives in the same cycle as the write, the tick is discarded.
- R3: While running, each `tick_en` cycle with a nonzero count lowers the count by one. Without a tick, or while stopped, the count holds.
- R4: With reload value L, expiry happens on the (L+1)th tick after the trigger write, which is the tick that finds the count at 0. `irq` is 1 in the cycle after that tick.
- R5: In repeat mode, expiry reloads the count with L and the timer keeps running, so expiries recur every L+1 ticks.
- R6: In single-shot mode, expiry stops the timer. The count stays 0 and later ticks produce no further expiry.
- R7: Writing 0 to the trigger word stops the timer with a count of 0. After that, no number of ticks raises `irq`.
- R8: `irq` is a level. It stays 1 until a write to word 1 (the status word) with bit 30 set. A status write with bit 30 clear leaves it unchanged.
- R9: If an expiry and an acknowledge write fall in the same cycle, the expiry wins and `irq` stays 1.
- R10: `reg_rdata` is registered. It shows the word selected by `reg_addr` at the previous clock edge. Word 1 returns the count in bits 28:0 with bits 31:29 at 0. Word 0 returns the live run flag at bit 31, the repeat flag at bit 30 and the reload value at bits 28:0.
- R11: The full reload value 0x1FFFFFFF is accepted. Trigger bit 29 is ignored and always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one pulse per tick |
| reg_addr | input | 1 | Word select: 0 trigger, 1 status |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected word |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
Two pairs of events can coincide in one cycle. The first is an expiry and an interrupt acknowledge. The bench provokes it by arming a short repeating timer, letting it expire once, and then driving the acknowledge write together with the tick that empties the count again. It judges the result by `irq` staying 1 afterwards. The second pair is a trigger write together with a tick. The bench judges it by reading back the unreduced new value from the status word.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned DTMR_DATA_W  = 32;
  localparam int unsigned DTMR_CNT_W   = 29;
  localparam int unsigned DTMR_RUN_POS = 31;
  localparam int unsigned DTMR_REP_POS = 30;
  localparam int unsigned DTMR_ACK_POS = 30;

  typedef enum logic {
    SEL_TRIG = 1'b0,
    SEL_STAT = 1'b1
  } dtmr_sel_e;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int unsigned DATA_W  = DTMR_DATA_W,
  parameter int unsigned CNT_W   = DTMR_CNT_W,
  parameter int unsigned RUN_POS = DTMR_RUN_POS,
  parameter int unsigned REP_POS = DTMR_REP_POS,
  parameter int unsigned ACK_POS = DTMR_ACK_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              run_q,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic              trig_wr,
  output logic              ack_wr,
  output logic              new_run,
  output logic              new_rep,
  output logic [CNT_W-1:0]  new_load,
  output logic              rep_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned GAP_W = REP_POS - CNT_W;

  dtmr_sel_e sel;
  logic [DATA_W-1:0] rd_d;

  assign sel      = dtmr_sel_e'(reg_addr);
  assign trig_wr  = reg_wr && (sel == SEL_TRIG);
  assign ack_wr   = reg_wr && (sel == SEL_STAT) && reg_wdata[ACK_POS];
  assign new_run  = reg_wdata[RUN_POS];
  assign new_rep  = reg_wdata[REP_POS];
  assign new_load = reg_wdata[CNT_W-1:0];

  // Bits between the count field and the mode flag carry no meaning.
  generate
    if (GAP_W > 0) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^reg_wdata[REP_POS-1:CNT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q  <= 1'b0;
      load_q <= '0;
    end else if (trig_wr) begin
      rep_q  <= new_rep;
      load_q <= new_load;
    end
  end

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_TRIG: begin
        rd_d[RUN_POS]   = run_q;
        rd_d[REP_POS]   = rep_q;
        rd_d[CNT_W-1:0] = load_q;
      end
      default: rd_d[CNT_W-1:0] = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             trig_wr,
  input  logic             new_run,
  input  logic [CNT_W-1:0] new_load,
  input  logic             rep_q,
  input  logic [CNT_W-1:0] load_q,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = tick_en && run_q && at_zero && !trig_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (trig_wr) begin
      cnt_q <= new_load;
      run_q <= new_run;
    end else if (tick_en && run_q) begin
      if (at_zero) begin
        if (rep_q) cnt_q <= load_q;
        else       run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ack_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)         irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (ack_wr) irq <= 1'b0;
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int unsigned DATA_W  = DTMR_DATA_W,
  parameter int unsigned CNT_W   = DTMR_CNT_W,
  parameter int unsigned RUN_POS = DTMR_RUN_POS,
  parameter int unsigned REP_POS = DTMR_REP_POS,
  parameter int unsigned ACK_POS = DTMR_ACK_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             trig_wr, ack_wr, new_run, new_rep, rep_q, run_q, expire;
  logic [CNT_W-1:0] new_load, load_q, cnt_q;

  dtmr_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RUN_POS(RUN_POS),
    .REP_POS(REP_POS), .ACK_POS(ACK_POS)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .run_q(run_q), .cnt_q(cnt_q),
    .trig_wr(trig_wr), .ack_wr(ack_wr), .new_run(new_run),
    .new_rep(new_rep), .new_load(new_load), .rep_q(rep_q),
    .load_q(load_q), .reg_rdata(reg_rdata)
  );

  dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trig_wr(trig_wr),
    .new_run(new_run), .new_load(new_load), .rep_q(rep_q),
    .load_q(load_q), .run_q(run_q), .cnt_q(cnt_q), .expire(expire)
  );

  dtmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .ack_wr(ack_wr), .irq(irq)
  );
endmodule

// File: rtl/dtmr_channel_chk.sv
module dtmr_channel_chk #(
  parameter int unsigned CNT_W = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             trig_wr,
  input logic             ack_wr,
  input logic             new_run,
  input logic [CNT_W-1:0] new_load,
  input logic             run_q,
  input logic             rep_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq
);
  logic hit;
  assign hit = tick_en && run_q && (cnt_q == '0) && !trig_wr;

  a_r2_load_takes: assert property (@(posedge clk) disable iff (rst)
    trig_wr |=> (cnt_q == $past(new_load)) && (run_q == $past(new_run)));

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_q && (cnt_q != '0) && !trig_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !trig_wr) |=> $stable(cnt_q));

  a_r4_expiry_raises: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);

  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (hit && rep_q) |=> (run_q && (cnt_q == $past(load_q))));

  a_r6_single_stop: assert property (@(posedge clk) disable iff (rst)
    (hit && !rep_q) |=> (!run_q && (cnt_q == '0)));

  a_r8_level_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_wr) |=> irq);

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !hit) |=> !irq);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && hit) |=> irq);
endmodule

bind dtmr_channel dtmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .trig_wr(trig_wr),
  .ack_wr(ack_wr), .new_run(new_run), .new_load(new_load),
  .run_q(run_q), .rep_q(rep_q), .load_q(load_q), .cnt_q(cnt_q), .irq(irq)
);

// File: tb/sim_dtmr_channel.sv
`timescale 1ns/1ps
module sim_dtmr_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reg_addr = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dtmr_channel u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam int N_VEC = 11;
  // trigger word, ticks applied, expected status count, expected irq
  localparam logic [31:0] V_CTRL [N_VEC] = '{
    32'h8000_0005, 32'h8000_0005, 32'h8000_0005, 32'hC000_0004,
    32'hC000_0004, 32'hC000_0004, 32'h8000_0000, 32'h0000_0007,
    32'h4000_0003, 32'hC000_0000, 32'hBFFF_FFFF};
  localparam int V_TICKS [N_VEC] = '{3, 6, 9, 5, 7, 3, 1, 4, 10, 3, 2};
  localparam logic [31:0] V_CNT [N_VEC] = '{
    32'd2, 32'd0, 32'd0, 32'd4, 32'd2, 32'd1, 32'd0, 32'd7,
    32'd3, 32'd0, 32'h1FFF_FFFD};
  localparam logic V_IRQ [N_VEC] = '{0, 1, 1, 1, 1, 0, 1, 0, 0, 1, 0};
  localparam string V_REQ [N_VEC] = '{
    "R3", "R4", "R6", "R5", "R5", "R3", "R4", "R3", "R3", "R5", "R11"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_word(input logic a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd_word(1'b1, v); chk("R1 status", v, 32'd0);
    rd_word(1'b0, v); chk("R1 trigger", v, 32'd0);

    // vector table
    for (int k = 0; k < N_VEC; k++) begin
      wr_word(1'b0, 32'h0);
      wr_word(1'b1, 32'h4000_0000);
      chk("R8 ack before vector", {31'd0, irq}, 32'd0);
      wr_word(1'b0, V_CTRL[k]);
      ticks(V_TICKS[k]);
      chk({V_REQ[k], " irq"}, {31'd0, irq}, {31'd0, V_IRQ[k]});
      rd_word(1'b1, v); chk({V_REQ[k], " count"}, v, V_CNT[k]);
    end

    // R11/R10 trigger readback drops bit 29
    wr_word(1'b0, 32'h0);
    wr_word(1'b1, 32'h4000_0000);
    wr_word(1'b0, 32'hE000_0123);
    rd_word(1'b0, v); chk("R10 R11 trigger readback", v, 32'hC000_0123);
    // R3 holds without ticks
    wr_word(1'b0, 32'h8000_0006);
    repeat (10) @(negedge clk);
    rd_word(1'b1, v); chk("R3 hold without tick", v, 32'd6);

    // R2 trigger write beats a same-cycle tick
    wr_word(1'b0, 32'hC000_0003);
    ticks(1);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h8000_0009;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd_word(1'b1, v); chk("R2 write beats tick", v, 32'd9);

    // R7 stop mid-count
    wr_word(1'b0, 32'h8000_0002);
    ticks(1);
    wr_word(1'b0, 32'h0);
    ticks(5);
    chk("R7 stopped irq", {31'd0, irq}, 32'd0);
    rd_word(1'b1, v); chk("R7 stopped count", v, 32'd0);

    // R8 level behaviour
    wr_word(1'b0, 32'h8000_0000);
    ticks(1);
    repeat (5) @(negedge clk);
    chk("R8 level holds", {31'd0, irq}, 32'd1);
    wr_word(1'b1, 32'h0000_0000);
    chk("R8 ack bit clear ignored", {31'd0, irq}, 32'd1);
    wr_word(1'b1, 32'h4000_0000);
    chk("R8 ack clears", {31'd0, irq}, 32'd0);

    // R9 expiry and ack in the same cycle
    wr_word(1'b0, 32'hC000_0001);
    ticks(2);
    chk("R9 first expiry", {31'd0, irq}, 32'd1);
    ticks(1);
    @(negedge clk);
    tick_en = 1'b1; reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h4000_0000;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    chk("R9 set wins over ack", {31'd0, irq}, 32'd1);
    wr_word(1'b1, 32'h4000_0000);
    chk("R9 later ack clears", {31'd0, irq}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule